// File: doc/BRIEF.md
# Grouped Two-Minimum Check Node Unit

This block is the check node stage of a layered min-sum decoder for quasi-cyclic LDPC codes. It takes one layer's prior messages in parallel, each an 8-bit sign-magnitude word, and produces the data that the extrinsic store keeps for that layer. That data is the overall sign, a sign for each edge, the exact smallest magnitude and its position, and an estimated second-smallest magnitude. The second value does not come from a full two-minimum sorter. The inputs are split into four groups of consecutive positions, and each group finds only its own minimum with single-output comparators. The smallest group minimum is the exact first minimum. The smallest of the remaining group minima stands in for the second minimum.

This estimate is too large whenever the true runner-up shares a group with the winner. To make up for that, the block pulls the estimate toward the first minimum by a power-of-two blend and then scales it by the same factor used for the first minimum. Both scaled values are saturated to 4-bit magnitudes. A mode input selects either the long layer of 19 edges or the short layer of 10 edges. Results appear one stage after the registered inputs, together with a valid flag.

Top module: `cnu_grouped_top`

## Requirements
- R1: While reset is asserted and after it is released, with no input applied, out_valid is 0 and every result output is 0.
- R2: out_idx is the position of the smallest active input magnitude (bits 8i+6..8i of in_msg). When magnitudes tie, the lowest position is reported.
- R3: out_min1 equals floor(3·m1/4) saturated to 15, where m1 is the smallest active magnitude.
- R4: Positions are grouped as 0–4, 5–9, 10–14 and 15–18. The estimate e is the smallest minimum among the groups that do not hold out_idx, and a group with no active input counts as 127. out_min2 equals floor(3·(m1+e)/8) saturated to 15.
- R5: out_sign_total is the XOR of the sign bits (bit 8i+7) of all active inputs.
- R6: For an active edge i, out_sign[i] equals out_sign_total XOR the sign of input i. For an inactive edge it equals out_sign_total.
- R7: When mode_short is 1, only positions 0–9 are active. The contents of positions 10–18 have no effect on any output.
- R8: A word sampled with in_valid high at one rising edge produces out_valid high with its results after the next rising edge, and out_valid is low otherwise.
- R9: While out_valid is low, all result outputs hold the last result, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Layer inputs are present |
| mode_short | input | 1 | 1 selects the 10-edge layer, 0 selects the 19-edge layer |
| in_msg | input | 152 | 19 sign-magnitude messages, edge i in bits 8i+7..8i |
| out_valid | output | 1 | Results are present |
| out_sign_total | output | 1 | XOR of all active signs |
| out_sign | output | 19 | Per-edge sign excluding the edge itself |
| out_min1 | output | 4 | Scaled first minimum |
| out_min2 | output | 4 | Compensated, scaled second minimum |
| out_idx | output | 5 | Position of the first minimum |

## Verification
Each result is due two rising edges after the bench presents a layer: the first edge captures the inputs and the second loads the outputs. The bench changes inputs on falling edges. It checks out_valid low on the falling edge after the capture edge, then checks every result field on the falling edge after the output edge, against a model computed from the requirement formulas. For the hold checks, the bench leaves in_valid low for several cycles while it scrambles in_msg and mode_short, and it compares the outputs on each falling edge.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int MSG_W = 8;
  localparam int MAG_W = MSG_W - 1;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
  } cnu_msg_t;
endpackage

// File: rtl/cnu_group_min.sv
module cnu_group_min #(
  parameter int MAG_W    = 7,
  parameter int GRP_SIZE = 5,
  parameter int IDX_W    = 5,
  parameter int BASE     = 0
) (
  input  logic [GRP_SIZE-1:0][MAG_W-1:0] mag_i,
  input  logic [GRP_SIZE-1:0]            en_i,
  output logic [MAG_W-1:0]               min_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic found;

  always_comb begin
    min_o = '1;
    idx_o = IDX_W'(BASE);
    found = 1'b0;
    for (int j = 0; j < GRP_SIZE; j++) begin
      if (en_i[j] && (!found || (mag_i[j] < min_o))) begin
        min_o = mag_i[j];
        idx_o = IDX_W'(BASE + j);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cnu_min_merge.sv
module cnu_min_merge #(
  parameter int MAG_W   = 7,
  parameter int IDX_W   = 5,
  parameter int NUM_GRP = 4
) (
  input  logic [NUM_GRP-1:0][MAG_W-1:0] gmin_i,
  input  logic [NUM_GRP-1:0][IDX_W-1:0] gidx_i,
  output logic [MAG_W-1:0]              min1_o,
  output logic [IDX_W-1:0]              idx1_o,
  output logic [MAG_W-1:0]              min2p_o
);
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [GW-1:0] win;

  always_comb begin
    win = '0;
    for (int g = 1; g < NUM_GRP; g++) begin
      if (gmin_i[g] < gmin_i[win]) win = GW'(g);
    end
    min1_o = gmin_i[win];
    idx1_o = gidx_i[win];
  end

  always_comb begin
    min2p_o = '1;
    for (int g = 0; g < NUM_GRP; g++) begin
      if ((GW'(g) != win) && (gmin_i[g] < min2p_o)) min2p_o = gmin_i[g];
    end
  end
endmodule

// File: rtl/cnu_scale.sv
module cnu_scale #(
  parameter int MAG_W       = 7,
  parameter int OUT_W       = 4,
  parameter int GAMMA_NUM   = 3,
  parameter int GAMMA_SHIFT = 2,
  parameter int ALPHA_SHIFT = 1
) (
  input  logic [MAG_W-1:0] min1_i,
  input  logic [MAG_W-1:0] min2p_i,
  output logic [OUT_W-1:0] s1_o,
  output logic [OUT_W-1:0] s2_o
);
  localparam int SW = MAG_W + ALPHA_SHIFT + 8;
  localparam logic [SW-1:0] K_GAMMA = SW'(GAMMA_NUM);
  localparam logic [SW-1:0] K_BETA  = SW'((1 << ALPHA_SHIFT) - 1);
  localparam logic [SW-1:0] SAT     = SW'((1 << OUT_W) - 1);

  logic [SW-1:0] w1, w2, blend, p1, p2;

  always_comb begin
    w1    = SW'(min1_i);
    w2    = SW'(min2p_i);
    blend = w1 + K_BETA * w2;
    p1    = (K_GAMMA * w1) >> GAMMA_SHIFT;
    p2    = (K_GAMMA * blend) >> (GAMMA_SHIFT + ALPHA_SHIFT);
    s1_o  = (p1 > SAT) ? SAT[OUT_W-1:0] : p1[OUT_W-1:0];
    s2_o  = (p2 > SAT) ? SAT[OUT_W-1:0] : p2[OUT_W-1:0];
  end
endmodule

// File: rtl/cnu_grouped_top.sv
module cnu_grouped_top #(
  parameter int NUM_IN       = 19,
  parameter int NUM_IN_SHORT = 10,
  parameter int NUM_GRP      = 4,
  parameter int OUT_W        = 4,
  parameter int IDX_W        = 5,
  parameter int GAMMA_NUM    = 3,
  parameter int GAMMA_SHIFT  = 2,
  parameter int ALPHA_SHIFT  = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic                             mode_short,
  input  logic [NUM_IN*cnu_pkg::MSG_W-1:0] in_msg,
  output logic                             out_valid,
  output logic                             out_sign_total,
  output logic [NUM_IN-1:0]                out_sign,
  output logic [OUT_W-1:0]                 out_min1,
  output logic [OUT_W-1:0]                 out_min2,
  output logic [IDX_W-1:0]                 out_idx
);
  import cnu_pkg::*;

  localparam int GRP_SIZE = (NUM_IN + NUM_GRP - 1) / NUM_GRP;

  // stage 0: input capture
  logic                    v0_q, v0_d;
  logic                    mode_q, mode_d;
  logic [NUM_IN*MSG_W-1:0] msg_q, msg_d;

  always_comb begin
    v0_d   = in_valid;
    mode_d = in_valid ? mode_short : mode_q;
    msg_d  = in_valid ? in_msg : msg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q   <= 1'b0;
      mode_q <= 1'b0;
      msg_q  <= '0;
    end else begin
      v0_q <= v0_d;
      if (in_valid) begin
        mode_q <= mode_d;
        msg_q  <= msg_d;
      end
    end
  end

  // unpack, mask inactive edges
  cnu_msg_t    msg_a [NUM_IN];
  logic [NUM_IN-1:0] act;
  logic [NUM_IN-1:0] sgn_act;

  genvar i;
  generate
    for (i = 0; i < NUM_IN; i++) begin : g_edge
      assign msg_a[i]   = msg_q[i*MSG_W +: MSG_W];
      if (i < NUM_IN_SHORT) begin : g_always
        assign act[i] = 1'b1;
      end else begin : g_long_only
        assign act[i] = ~mode_q;
      end
      assign sgn_act[i] = msg_a[i].sign & act[i];
    end
  endgenerate

  // group search
  logic [NUM_GRP-1:0][MAG_W-1:0] gmin;
  logic [NUM_GRP-1:0][IDX_W-1:0] gidx;

  genvar g, j;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [GRP_SIZE-1:0][MAG_W-1:0] gmag;
      logic [GRP_SIZE-1:0]            gen;
      for (j = 0; j < GRP_SIZE; j++) begin : g_slot
        if (g * GRP_SIZE + j < NUM_IN) begin : g_real
          assign gmag[j] = msg_a[g*GRP_SIZE+j].mag;
          assign gen[j]  = act[g*GRP_SIZE+j];
        end else begin : g_pad
          assign gmag[j] = '1;
          assign gen[j]  = 1'b0;
        end
      end
      cnu_group_min #(
        .MAG_W   (MAG_W),
        .GRP_SIZE(GRP_SIZE),
        .IDX_W   (IDX_W),
        .BASE    (g * GRP_SIZE)
      ) u_gmin (
        .mag_i(gmag),
        .en_i (gen),
        .min_o(gmin[g]),
        .idx_o(gidx[g])
      );
    end
  endgenerate

  logic [MAG_W-1:0] min1, min2p;
  logic [IDX_W-1:0] idx1;

  cnu_min_merge #(
    .MAG_W  (MAG_W),
    .IDX_W  (IDX_W),
    .NUM_GRP(NUM_GRP)
  ) u_merge (
    .gmin_i (gmin),
    .gidx_i (gidx),
    .min1_o (min1),
    .idx1_o (idx1),
    .min2p_o(min2p)
  );

  logic [OUT_W-1:0] s1, s2;

  cnu_scale #(
    .MAG_W      (MAG_W),
    .OUT_W      (OUT_W),
    .GAMMA_NUM  (GAMMA_NUM),
    .GAMMA_SHIFT(GAMMA_SHIFT),
    .ALPHA_SHIFT(ALPHA_SHIFT)
  ) u_scale (
    .min1_i (min1),
    .min2p_i(min2p),
    .s1_o   (s1),
    .s2_o   (s2)
  );

  // stage 1: results
  logic              tot_d;
  logic [NUM_IN-1:0] esgn_d;

  always_comb begin
    tot_d  = ^sgn_act;
    esgn_d = sgn_act ^ {NUM_IN{tot_d}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_sign_total <= 1'b0;
      out_sign       <= '0;
      out_min1       <= '0;
      out_min2       <= '0;
      out_idx        <= '0;
    end else begin
      out_valid <= v0_q;
      if (v0_q) begin
        out_sign_total <= tot_d;
        out_sign       <= esgn_d;
        out_min1       <= s1;
        out_min2       <= s2;
        out_idx        <= idx1;
      end
    end
  end
endmodule

// File: rtl/cnu_checker.sv
module cnu_checker #(
  parameter int NUM_IN       = 19,
  parameter int NUM_IN_SHORT = 10,
  parameter int OUT_W        = 4,
  parameter int IDX_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mode_short,
  input logic              out_valid,
  input logic              out_sign_total,
  input logic [NUM_IN-1:0] out_sign,
  input logic [OUT_W-1:0]  out_min1,
  input logic [OUT_W-1:0]  out_min2,
  input logic [IDX_W-1:0]  out_idx
);
  logic [NUM_IN-1:0] own;
  assign own = out_sign ^ {NUM_IN{out_sign_total}};

  p_lat_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_lat_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  p_min_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_min2 >= out_min1));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(mode_short, 2) ? (out_idx < IDX_W'(NUM_IN_SHORT))
                                        : (out_idx < IDX_W'(NUM_IN))));

  p_sign_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((^own) == out_sign_total));

  p_short_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode_short, 2)) |-> (own[NUM_IN-1:NUM_IN_SHORT] == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_min1) && $stable(out_min2) && $stable(out_idx)
                    && $stable(out_sign) && $stable(out_sign_total)));
endmodule

bind cnu_grouped_top cnu_checker #(
  .NUM_IN      (NUM_IN),
  .NUM_IN_SHORT(NUM_IN_SHORT),
  .OUT_W       (OUT_W),
  .IDX_W       (IDX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .mode_short    (mode_short),
  .out_valid     (out_valid),
  .out_sign_total(out_sign_total),
  .out_sign      (out_sign),
  .out_min1      (out_min1),
  .out_min2      (out_min2),
  .out_idx       (out_idx)
);

// File: tb/sim_cnu_grouped_top.sv
module sim_cnu_grouped_top;
  localparam int NI = 19;
  localparam int NS = 10;
  localparam int W  = NI * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          mode_short = 1'b0;
  logic [W-1:0]  in_msg = '0;
  logic          out_valid, out_sign_total;
  logic [NI-1:0] out_sign;
  logic [3:0]    out_min1, out_min2;
  logic [4:0]    out_idx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cnu_grouped_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_short(mode_short),
    .in_msg(in_msg), .out_valid(out_valid), .out_sign_total(out_sign_total),
    .out_sign(out_sign), .out_min1(out_min1), .out_min2(out_min2), .out_idx(out_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected values from the requirement formulas
  logic          e_tot;
  logic [NI-1:0] e_sgn;
  int            e_m1, e_m2, e_idx;

  task automatic model(input logic [W-1:0] m, input logic sh);
    int n, m1, ix, e, gm[4], s1, s2;
    n = sh ? NS : NI;
    m1 = 1000; ix = 0; e_tot = 1'b0;
    for (int g = 0; g < 4; g++) gm[g] = 127;
    for (int i = 0; i < n; i++) begin
      int mg;
      mg = int'(m[8*i +: 7]);
      e_tot ^= m[8*i+7];
      if (mg < m1) begin m1 = mg; ix = i; end
      if (mg < gm[i/5]) gm[i/5] = mg;
    end
    e = 127;
    for (int g = 0; g < 4; g++) if (g != ix/5 && gm[g] < e) e = gm[g];
    for (int i = 0; i < NI; i++) e_sgn[i] = (i < n) ? (e_tot ^ m[8*i+7]) : e_tot;
    s1 = (3 * m1) / 4;
    s2 = (3 * (m1 + e)) / 8;
    e_m1 = (s1 > 15) ? 15 : s1;
    e_m2 = (s2 > 15) ? 15 : s2;
    e_idx = ix;
  endtask

  task automatic apply(input logic [W-1:0] m, input logic sh);
    @(negedge clk);
    in_msg = m; mode_short = sh; in_valid = 1'b1;
    model(m, sh);
    @(negedge clk);
    in_valid = 1'b0;
    in_msg = {W{1'b1}} ^ m;
    chk(out_valid == 1'b0, "R8 early valid", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
    chk(out_idx == 5'(e_idx), "R2 idx", int'(out_idx), e_idx);
    chk(out_min1 == 4'(e_m1), "R3 min1", int'(out_min1), e_m1);
    chk(out_min2 == 4'(e_m2), "R4 min2", int'(out_min2), e_m2);
    chk(out_sign_total == e_tot, "R5 total sign", int'(out_sign_total), int'(e_tot));
    chk(out_sign == e_sgn, "R6 edge signs", int'(out_sign), int'(e_sgn));
  endtask

  function automatic logic [W-1:0] fill(input int mag);
    logic [W-1:0] v;
    for (int i = 0; i < NI; i++) v[8*i +: 8] = {1'b0, 7'(mag)};
    return v;
  endfunction

  function automatic logic [W-1:0] rnd(input int hi);
    logic [W-1:0] v;
    for (int i = 0; i < NI; i++)
      v[8*i +: 8] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, hi))};
    return v;
  endfunction

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    logic [3:0] h1, h2;
    logic [4:0] hi;
    void'($urandom(32'd20240611));
    #1;
    chk(out_valid == 1'b0 && out_min1 == 0 && out_min2 == 0 && out_idx == 0
        && out_sign == 0 && out_sign_total == 0, "R1 in reset", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_min1 == 0 && out_min2 == 0 && out_idx == 0,
        "R1 after release", int'(out_min1), 0);

    // R4: runner-up sits in the winner's group
    v = fill(20); v[7:0] = 8'd3; v[15:8] = 8'd4;
    apply(v, 1'b0);
    chk(out_min2 == 4'd8, "R4 same group estimate", int'(out_min2), 8);

    // R2: tie, lowest position wins
    v = fill(50); v[8*7 +: 8] = 8'd9; v[8*2 +: 8] = 8'h89;
    apply(v, 1'b0);
    chk(out_idx == 5'd2, "R2 tie", int'(out_idx), 2);

    // R3/R4 saturation and all-zero layer
    apply(fill(127), 1'b0);
    chk(out_min1 == 4'd15 && out_min2 == 4'd15, "R3 saturate", int'(out_min1), 15);
    apply(fill(0), 1'b0);

    // R7: junk in the upper positions under short mode
    v = fill(40); v[8*4 +: 8] = 8'h8C;
    for (int i = NS; i < NI; i++) v[8*i +: 8] = 8'h80;
    apply(v, 1'b1);
    chk(out_idx == 5'd4 && out_min1 == 4'd9, "R7 upper ignored", int'(out_idx), 4);
    chk(out_sign_total == 1'b1, "R7 sign ignored", int'(out_sign_total), 1);

    // R9: hold while idle with scrambled inputs
    h1 = out_min1; h2 = out_min2; hi = out_idx;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_msg = rnd(127); mode_short = ~mode_short;
      chk(!out_valid && out_min1 == h1 && out_min2 == h2 && out_idx == hi,
          "R9 hold", int'(out_min1), int'(h1));
    end

    // random layers, both modes, wide and narrow magnitude spread
    for (int k = 0; k < 300; k++)
      apply(rnd((k % 3 == 0) ? 5 : 127), 1'($urandom_range(0, 1)));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule